// File: doc/BRIEF.md
# Regulator Control Register Bank with Two-Wire Target Interface

This block is the digital control port of a step-down regulator controller. It acts as a target on a two-wire I2C bus, sampling SCL and SDA with the system clock. It recognises START, repeated START and STOP, answers its fixed 7-bit address, and pulls SDA low (open drain) for acknowledge bits and for zero data bits. The configuration fields it holds drive the rest of the controller directly as parallel outputs: per-preset enable, output-voltage code, forced-PWM mode and voltage bank, plus discharge enable, current-limit level and the upper and lower voltage-code limits.

A host writes a register address and then any number of data bytes, which land at consecutive addresses. To read, the host sets the address the same way, issues a repeated START with the read bit, and clocks out consecutive bytes. Three fault inputs (over-current, short circuit, input under-voltage) are single-cycle pulses that set sticky flags; the host clears a flag by writing 0 to its bit. Two live status inputs (thermal shutdown, power good) can be read. Only the power-on reset restores the defaults, so the bus and all settings stay valid while the regulator itself is switched off.

The target FSM has these states. `ST_IDLE` waits for START. `ST_DEVADDR` shifts in the address byte. On a match it moves to `ST_DEV_ACK`; on a mismatch it moves to `ST_SKIP`, which waits for the next START or STOP. After a write header, `ST_REGADDR` takes the register pointer and `ST_REG_ACK` acknowledges it. Each data byte then passes through `ST_WDATA` and `ST_WDATA_ACK`. After a read header, `ST_RDATA` shifts a byte out and `ST_RDATA_ACK` samples the host's acknowledge. An acknowledge from the host returns the FSM to `ST_RDATA`; a not-acknowledge sends it to `ST_SKIP`. START from any state enters `ST_DEVADDR`, and STOP from any state enters `ST_IDLE`. The FSM advances on falling SCL edges; bits are sampled on rising SCL edges.

Top module: `vreg_i2c_regbank`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x1C (address byte `{addr, rw}`, rw=0 write, rw=1 read). Any other address gets no acknowledge, and the bytes that follow have no effect on any register.
- R2: A write sets the register pointer from the first data byte, then stores each following byte at the pointer and increments it. Every byte is acknowledged.
- R3: A read returns bytes starting at the pointer set before the repeated START and increments the pointer after each byte. The host's not-acknowledge ends the read, and SDA is released.
- R4: After reset, the register fields read back and drive these outputs. 0x10 = {en_hi=1 at bit 7, vsel_hi at bits 6:0 = 0x50}. 0x11 = {en_lo=1 at bit 7, vsel_lo at bits 6:0 = 0x28}. 0x12 bit 4: discharge = 1. 0x14: bit 7 fpwm_lo = 1, bit 6 fpwm_hi = 1. 0x16 bits 7:6: ipeak = 3. 0x1C bits 1:0: bank_hi = 2. 0x1D bits 1:0: bank_lo = 1. 0x1E: vmax at bits 7:4 = 0xF, vmin at bits 3:0 = 0. All fault flags are 0, and SDA is released.
- R5: Configuration outputs change only through a bus write. Fault pulses, status inputs and reads leave them unchanged.
- R6: Register 0x18 holds sticky flags: over-current at bit 7, short circuit at bit 4, under-voltage at bit 1. A one-cycle pulse sets a flag, and reading does not clear it. Writing 0 to a flag bit clears that flag; writing 1 leaves it unchanged.
- R7: When a fault pulse arrives in the same clock cycle as a write that clears its flag, the flag ends set.
- R8: Reserved bits read 0 and ignore writes. Unmapped addresses read 0x00, still acknowledge written bytes, and ignore the data.
- R9: Register 0x01 is read-only. Bit 7 shows the live thermal input and bit 0 the live power-good input; writes to it have no effect.
- R10: STOP from any state, including in the middle of a byte, returns the target to idle with SDA released and no write performed. START from any state begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| evt_ocp | input | 1 | Over-current event pulse |
| evt_scp | input | 1 | Short-circuit event pulse |
| evt_uvlo | input | 1 | Input under-voltage event pulse |
| st_thermal | input | 1 | Live thermal-shutdown status |
| st_pgood | input | 1 | Live power-good status |
| cfg_en_hi | output | 1 | Enable for the high preset |
| cfg_vsel_hi | output | 7 | Voltage code for the high preset |
| cfg_en_lo | output | 1 | Enable for the low preset |
| cfg_vsel_lo | output | 7 | Voltage code for the low preset |
| cfg_fpwm_lo | output | 1 | Forced PWM for the low preset |
| cfg_fpwm_hi | output | 1 | Forced PWM for the high preset |
| cfg_discharge | output | 1 | Output discharge enable |
| cfg_ipeak | output | 2 | Peak current limit level |
| cfg_bank_hi | output | 2 | Voltage bank for the high preset |
| cfg_bank_lo | output | 2 | Voltage bank for the low preset |
| cfg_vmax | output | 4 | Upper voltage-code limit |
| cfg_vmin | output | 4 | Lower voltage-code limit |

## Verification
With two synchroniser stages, a falling SCL edge becomes visible to the FSM on the second clock edge after it and acts on the third. The acknowledge drive, each read bit and each register write therefore change three clocks after the SCL fall that triggers them. The bench drives SDA no earlier than two clocks after a fall and samples SDA six clocks after the fall, near the middle of the SCL high phase. It checks configuration outputs only after STOP, when they have long settled. For the same-cycle priority case, the bench places a one-cycle fault pulse exactly over the third clock edge after the final data-bit fall, which is the cycle in which the clearing write takes effect.

// File: rtl/vreg_i2c_pkg.sv
package vreg_i2c_pkg;

    localparam logic [7:0] RA_STATUS  = 8'h01;
    localparam logic [7:0] RA_SET_HI  = 8'h10;
    localparam logic [7:0] RA_SET_LO  = 8'h11;
    localparam logic [7:0] RA_OUTCTL  = 8'h12;
    localparam logic [7:0] RA_MODE    = 8'h14;
    localparam logic [7:0] RA_ILIM    = 8'h16;
    localparam logic [7:0] RA_FLAGS   = 8'h18;
    localparam logic [7:0] RA_BANK_HI = 8'h1C;
    localparam logic [7:0] RA_BANK_LO = 8'h1D;
    localparam logic [7:0] RA_LIMITS  = 8'h1E;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEVADDR, ST_DEV_ACK, ST_REGADDR, ST_REG_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_SKIP
    } bus_state_t;

    // bits that may read back as 1 at each address
    function automatic logic [7:0] rd_mask(input logic [7:0] a);
        case (a)
            RA_STATUS:                     return 8'h81;
            RA_SET_HI, RA_SET_LO, RA_LIMITS: return 8'hFF;
            RA_OUTCTL:                     return 8'h10;
            RA_MODE, RA_ILIM:              return 8'hC0;
            RA_FLAGS:                      return 8'h92;
            RA_BANK_HI, RA_BANK_LO:        return 8'h03;
            default:                       return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    localparam int NOW = STAGES - 1;

    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    always_comb begin
        scl_rise  =  scl_q[NOW] & ~scl_q[STAGES];
        scl_fall  = ~scl_q[NOW] &  scl_q[STAGES];
        sda_s     =  sda_q[NOW];
        start_det =  scl_q[NOW] & scl_q[STAGES] & ~sda_q[NOW] &  sda_q[STAGES];
        stop_det  =  scl_q[NOW] & scl_q[STAGES] &  sda_q[NOW] & ~sda_q[STAGES];
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import vreg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_s,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic [7:0] rd_addr
);
    bus_state_t state, state_nx;
    logic [7:0] shreg;
    logic [3:0] cnt;
    logic [7:0] ptr;
    logic       mst_nack;
    logic       byte_done, rx_state, addr_hit;

    assign byte_done = (cnt == 4'd8);
    assign rx_state  = (state == ST_DEVADDR) || (state == ST_REGADDR) || (state == ST_WDATA);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);

    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_DEVADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_DEVADDR:   if (byte_done) state_nx = addr_hit ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:   state_nx = shreg[0] ? ST_RDATA : ST_REGADDR;
                ST_REGADDR:   if (byte_done) state_nx = ST_REG_ACK;
                ST_REG_ACK:   state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: state_nx = ST_WDATA;
                ST_RDATA:     if (cnt == 4'd7) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: state_nx = mst_nack ? ST_SKIP : ST_RDATA;
                default:      state_nx = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            ptr      <= '0;
            mst_nack <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else if (scl_rise && rx_state && !byte_done) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
        end else if (scl_rise && state == ST_RDATA_ACK) begin
            mst_nack <= sda_s;
        end else if (scl_fall) begin
            unique case (state)
                ST_DEVADDR: if (byte_done) cnt <= '0;
                ST_REGADDR: if (byte_done) begin
                    cnt <= '0;
                    ptr <= shreg;
                end
                ST_WDATA: if (byte_done) begin
                    cnt <= '0;
                    ptr <= ptr + 8'd1;
                end
                ST_DEV_ACK: if (shreg[0]) begin
                    shreg <= rd_data;
                    cnt   <= '0;
                end
                ST_RDATA: begin
                    shreg <= {shreg[6:0], 1'b0};
                    if (cnt == 4'd7) begin
                        cnt <= '0;
                        ptr <= ptr + 8'd1;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                ST_RDATA_ACK: begin
                    shreg <= rd_data;
                    cnt   <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sda_oe  = (state == ST_DEV_ACK) || (state == ST_REG_ACK) || (state == ST_WDATA_ACK)
                  || ((state == ST_RDATA) && !shreg[7]);
        wr_en   = (state == ST_WDATA) && scl_fall && byte_done && !start_det && !stop_det;
        wr_addr = ptr;
        wr_data = shreg;
        rd_addr = ptr;
    end

    AST_NOACK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEVADDR && scl_fall && byte_done && shreg[7:1] != DEV_ADDR) |=> !sda_oe); // R1
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe && !wr_en); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R10

endmodule

// File: rtl/vreg_reg_store.sv
module vreg_reg_store
    import vreg_i2c_pkg::*;
#(
    parameter logic [6:0] DEF_VSEL_HI = 7'h50,
    parameter logic [6:0] DEF_VSEL_LO = 7'h28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       evt_ocp,
    input  logic       evt_scp,
    input  logic       evt_uvlo,
    input  logic       st_thermal,
    input  logic       st_pgood,
    output logic [7:0] set_hi_o,
    output logic [7:0] set_lo_o,
    output logic [1:0] mode_o,
    output logic       discharge_o,
    output logic [1:0] ipeak_o,
    output logic [1:0] bank_hi_o,
    output logic [1:0] bank_lo_o,
    output logic [7:0] limits_o
);
    logic [7:0] set_hi, set_lo, limits;
    logic [1:0] mode, ilim, bank_hi, bank_lo;
    logic       dis_en;
    logic       ocp_f, scp_f, uvlo_f;
    logic       flag_wr;

    assign flag_wr = wr_en && (wr_addr == RA_FLAGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_hi  <= {1'b1, DEF_VSEL_HI};
            set_lo  <= {1'b1, DEF_VSEL_LO};
            dis_en  <= 1'b1;
            mode    <= 2'b11;
            ilim    <= 2'b11;
            bank_hi <= 2'b10;
            bank_lo <= 2'b01;
            limits  <= 8'hF0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_SET_HI:  set_hi  <= wr_data;
                RA_SET_LO:  set_lo  <= wr_data;
                RA_OUTCTL:  dis_en  <= wr_data[4];
                RA_MODE:    mode    <= wr_data[7:6];
                RA_ILIM:    ilim    <= wr_data[7:6];
                RA_BANK_HI: bank_hi <= wr_data[1:0];
                RA_BANK_LO: bank_lo <= wr_data[1:0];
                RA_LIMITS:  limits  <= wr_data;
                default: ;
            endcase
        end
    end

    // event pulse wins over a clearing write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocp_f  <= 1'b0;
            scp_f  <= 1'b0;
            uvlo_f <= 1'b0;
        end else begin
            ocp_f  <= evt_ocp  | (ocp_f  & ~(flag_wr & ~wr_data[7]));
            scp_f  <= evt_scp  | (scp_f  & ~(flag_wr & ~wr_data[4]));
            uvlo_f <= evt_uvlo | (uvlo_f & ~(flag_wr & ~wr_data[1]));
        end
    end

    always_comb begin
        case (rd_addr)
            RA_STATUS:  rd_data = {st_thermal, 6'b0, st_pgood};
            RA_SET_HI:  rd_data = set_hi;
            RA_SET_LO:  rd_data = set_lo;
            RA_OUTCTL:  rd_data = {3'b0, dis_en, 4'b0};
            RA_MODE:    rd_data = {mode, 6'b0};
            RA_ILIM:    rd_data = {ilim, 6'b0};
            RA_FLAGS:   rd_data = {ocp_f, 2'b0, scp_f, 2'b0, uvlo_f, 1'b0};
            RA_BANK_HI: rd_data = {6'b0, bank_hi};
            RA_BANK_LO: rd_data = {6'b0, bank_lo};
            RA_LIMITS:  rd_data = limits;
            default:    rd_data = 8'h00;
        endcase
        set_hi_o    = set_hi;
        set_lo_o    = set_lo;
        mode_o      = mode;
        discharge_o = dis_en;
        ipeak_o     = ilim;
        bank_hi_o   = bank_hi;
        bank_lo_o   = bank_lo;
        limits_o    = limits;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ocp |=> ocp_f); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scp_f && !flag_wr) |=> scp_f); // R6
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ilim) && $stable(set_hi) && $stable(limits)); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~rd_mask(rd_addr)) == 8'h00); // R8

endmodule

// File: rtl/vreg_i2c_regbank.sv
module vreg_i2c_regbank #(
    parameter logic [6:0] DEV_ADDR    = 7'h1C,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEF_VSEL_HI = 7'h50,
    parameter logic [6:0] DEF_VSEL_LO = 7'h28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       evt_ocp,
    input  logic       evt_scp,
    input  logic       evt_uvlo,
    input  logic       st_thermal,
    input  logic       st_pgood,
    output logic       cfg_en_hi,
    output logic [6:0] cfg_vsel_hi,
    output logic       cfg_en_lo,
    output logic [6:0] cfg_vsel_lo,
    output logic       cfg_fpwm_lo,
    output logic       cfg_fpwm_hi,
    output logic       cfg_discharge,
    output logic [1:0] cfg_ipeak,
    output logic [1:0] cfg_bank_hi,
    output logic [1:0] cfg_bank_lo,
    output logic [3:0] cfg_vmax,
    output logic [3:0] cfg_vmin
);
    logic       scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [7:0] set_hi, set_lo, limits;
    logic [1:0] mode;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
    );

    vreg_reg_store #(.DEF_VSEL_HI(DEF_VSEL_HI), .DEF_VSEL_LO(DEF_VSEL_LO)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_ocp(evt_ocp), .evt_scp(evt_scp), .evt_uvlo(evt_uvlo),
        .st_thermal(st_thermal), .st_pgood(st_pgood),
        .set_hi_o(set_hi), .set_lo_o(set_lo), .mode_o(mode),
        .discharge_o(cfg_discharge), .ipeak_o(cfg_ipeak),
        .bank_hi_o(cfg_bank_hi), .bank_lo_o(cfg_bank_lo), .limits_o(limits)
    );

    assign cfg_en_hi   = set_hi[7];
    assign cfg_vsel_hi = set_hi[6:0];
    assign cfg_en_lo   = set_lo[7];
    assign cfg_vsel_lo = set_lo[6:0];
    assign cfg_fpwm_lo = mode[1];
    assign cfg_fpwm_hi = mode[0];
    assign cfg_vmax    = limits[7:4];
    assign cfg_vmin    = limits[3:0];

endmodule

// File: tb/vreg_i2c_regbank_test.sv
module vreg_i2c_regbank_test;
    localparam logic [6:0] DEV = 7'h1C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic evt_ocp = 1'b0, evt_scp = 1'b0, evt_uvlo = 1'b0;
    logic st_thermal = 1'b0, st_pgood = 1'b0;
    logic sda_oe;
    logic cfg_en_hi, cfg_en_lo, cfg_fpwm_lo, cfg_fpwm_hi, cfg_discharge;
    logic [6:0] cfg_vsel_hi, cfg_vsel_lo;
    logic [1:0] cfg_ipeak, cfg_bank_hi, cfg_bank_lo;
    logic [3:0] cfg_vmax, cfg_vmin;
    wire sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    vreg_i2c_regbank uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .evt_ocp(evt_ocp), .evt_scp(evt_scp), .evt_uvlo(evt_uvlo),
        .st_thermal(st_thermal), .st_pgood(st_pgood),
        .cfg_en_hi(cfg_en_hi), .cfg_vsel_hi(cfg_vsel_hi), .cfg_en_lo(cfg_en_lo),
        .cfg_vsel_lo(cfg_vsel_lo), .cfg_fpwm_lo(cfg_fpwm_lo), .cfg_fpwm_hi(cfg_fpwm_hi),
        .cfg_discharge(cfg_discharge), .cfg_ipeak(cfg_ipeak), .cfg_bank_hi(cfg_bank_hi),
        .cfg_bank_lo(cfg_bank_lo), .cfg_vmax(cfg_vmax), .cfg_vmin(cfg_vmin)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mdl [0:31];
    logic [7:0] mflags = 8'h00;
    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:15];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bmask(input logic [7:0] a);
        case (a)
            8'h10, 8'h11, 8'h1E: return 8'hFF;
            8'h12:               return 8'h10;
            8'h14, 8'h16:        return 8'hC0;
            8'h1C, 8'h1D:        return 8'h03;
            default:             return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] def_of(input logic [7:0] a);
        case (a)
            8'h10: return 8'hD0;
            8'h11: return 8'hA8;
            8'h12: return 8'h10;
            8'h14, 8'h16: return 8'hC0;
            8'h1C: return 8'h02;
            8'h1D: return 8'h01;
            8'h1E: return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h01) return {st_thermal, 6'b0, st_pgood};
        if (a == 8'h18) return mflags;
        if (a < 8'h20)  return mdl[a[4:0]];
        return 8'h00;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1; tick(2); scl_m = 1; tick(4); sda_m = 0; tick(4); scl_m = 0; tick(2);
    endtask

    task automatic bus_stop;
        sda_m = 0; tick(2); scl_m = 1; tick(4); sda_m = 1; tick(4);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit hit_evt, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(2); sda_m = b[i]; tick(2); scl_m = 1; tick(4); scl_m = 0;
        end
        if (hit_evt) begin
            @(posedge clk); @(posedge clk); @(negedge clk); evt_ocp = 1;
            @(negedge clk); evt_ocp = 0;
        end else begin
            tick(2);
        end
        sda_m = 1; tick(2); scl_m = 1; tick(2); ack = sda_bus; tick(2); scl_m = 0;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(4); scl_m = 1; tick(2); b[i] = sda_bus; tick(2); scl_m = 0;
        end
        tick(2); sda_m = mack; tick(2); scl_m = 1; tick(4); scl_m = 0; tick(2); sda_m = 1;
    endtask

    task automatic bus_write(input logic [7:0] a, input int n, input int evt_at);
        logic ack;
        bus_start;
        put_byte({DEV, 1'b0}, 0, ack); check("R2 address ack", ack, 0);
        put_byte(a, 0, ack);           check("R2 pointer ack", ack, 0);
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k], k == evt_at, ack);
            check("R8 data ack (mapped or not)", ack, 0);
        end
        bus_stop;
        for (int k = 0; k < n; k++) begin
            logic [7:0] ad;
            ad = a + k[7:0];
            if (ad == 8'h18) mflags = mflags & wbuf[k] & 8'h92;
            else if (ad < 8'h20 && ad != 8'h01) mdl[ad[4:0]] = wbuf[k] & bmask(ad);
        end
        if (evt_at >= 0) mflags = mflags | 8'h80;
    endtask

    task automatic bus_read(input logic [7:0] a, input int n);
        logic ack;
        bus_start;
        put_byte({DEV, 1'b0}, 0, ack); check("R3 write header ack", ack, 0);
        put_byte(a, 0, ack);           check("R3 pointer ack", ack, 0);
        bus_start;
        put_byte({DEV, 1'b1}, 0, ack); check("R3 read header ack", ack, 0);
        for (int k = 0; k < n; k++) get_byte(k == n - 1, rbuf[k]);
        bus_stop;
        check("R3 SDA released after read", sda_oe, 0);
    endtask

    task automatic check_cfg(input string req);
        check(req, {cfg_en_hi, cfg_vsel_hi}, mdl[5'h10]);
        check(req, {cfg_en_lo, cfg_vsel_lo}, mdl[5'h11]);
        check(req, cfg_discharge, mdl[5'h12][4]);
        check(req, {cfg_fpwm_lo, cfg_fpwm_hi}, mdl[5'h14][7:6]);
        check(req, cfg_ipeak, mdl[5'h16][7:6]);
        check(req, cfg_bank_hi, mdl[5'h1C][1:0]);
        check(req, cfg_bank_lo, mdl[5'h1D][1:0]);
        check(req, {cfg_vmax, cfg_vmin}, mdl[5'h1E]);
    endtask

    task automatic read_compare(input logic [7:0] a, input int n, input string req);
        bus_read(a, n);
        for (int k = 0; k < n; k++) check(req, rbuf[k], exp_rd(a + k[7:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        for (int a = 0; a < 32; a++) mdl[a] = def_of(a[7:0]);
        tick(5); rst_n = 1; tick(5);

        // R4 reset state at the outputs and through the bus
        check("R4 SDA released", sda_oe, 0);
        check_cfg("R4 reset default");
        read_compare(8'h10, 15, "R4 R8 default readback");
        read_compare(8'h18, 1, "R4 flags clear");

        // R1 sweep of every 7-bit address in the header
        for (int a = 0; a < 128; a++) begin
            bus_start;
            put_byte({a[6:0], 1'b0}, 0, ack);
            check("R1 address sweep", ack, (a[6:0] == DEV) ? 1'b0 : 1'b1);
            bus_stop;
        end
        // R1 foreign address write has no effect
        bus_start;
        put_byte({7'h1D, 1'b0}, 0, ack); check("R1 foreign nack", ack, 1);
        put_byte(8'h16, 0, ack);
        put_byte(8'h00, 0, ack);
        bus_stop;
        check_cfg("R1 foreign write ignored");

        // R2 R3 burst write and burst read, several patterns
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 15; k++) wbuf[k] = 8'(k * 37 + p * 91 + 5);
            bus_write(8'h10, 15, -1);
            check_cfg("R2 burst write outputs");
            read_compare(8'h10, 15, "R3 R8 burst readback");
        end

        // R2 exhaustive current-limit field, reserved bits written as 1
        for (int v = 0; v < 4; v++) begin
            wbuf[0] = {v[1:0], 6'h3F};
            bus_write(8'h16, 1, -1);
            check("R2 ipeak field", cfg_ipeak, v[1:0]);
            read_compare(8'h16, 1, "R8 reserved reads zero");
        end

        // R8 unmapped write is acknowledged and ignored
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
        bus_write(8'h40, 2, -1);
        read_compare(8'h40, 2, "R8 unmapped reads 00");
        check_cfg("R8 unmapped write ignored");

        // R5 fault pulses and status pins leave configuration alone
        @(negedge clk); evt_ocp = 1; evt_scp = 1; evt_uvlo = 1; st_thermal = 1; st_pgood = 1;
        @(negedge clk); evt_ocp = 0; evt_scp = 0; evt_uvlo = 0;
        tick(5); st_thermal = 0; st_pgood = 0; tick(5);
        mflags = 8'h92;
        check_cfg("R5 config unchanged by fault and status");

        // R6 sticky behaviour
        read_compare(8'h18, 1, "R6 all flags set");
        read_compare(8'h18, 1, "R6 read does not clear");
        wbuf[0] = 8'h80;
        bus_write(8'h18, 1, -1);
        read_compare(8'h18, 1, "R6 write-0 clears, write-1 keeps");
        wbuf[0] = 8'h00;
        bus_write(8'h18, 1, -1);
        read_compare(8'h18, 1, "R6 all cleared");
        @(negedge clk); evt_scp = 1; @(negedge clk); evt_scp = 0;
        mflags = 8'h10;
        read_compare(8'h18, 1, "R6 single pulse sets short flag");

        // R7 event in the same cycle as its clearing write
        @(negedge clk); evt_ocp = 1; evt_uvlo = 1; @(negedge clk); evt_ocp = 0; evt_uvlo = 0;
        mflags = 8'h92;
        wbuf[0] = 8'h00;
        bus_write(8'h18, 1, 0);
        read_compare(8'h18, 1, "R7 event beats clear");
        check("R7 flag value", mflags, 8'h80);

        // R9 live status, every input combination, and a write attempt
        for (int s = 0; s < 4; s++) begin
            st_thermal = s[1]; st_pgood = s[0];
            read_compare(8'h01, 1, "R9 live status");
        end
        wbuf[0] = 8'h00;
        bus_write(8'h01, 1, -1);
        read_compare(8'h01, 1, "R9 status write ignored");
        st_thermal = 0; st_pgood = 0;

        // R10 STOP in the middle of a data byte
        bus_start;
        put_byte({DEV, 1'b0}, 0, ack);
        put_byte(8'h16, 0, ack);
        for (int i = 0; i < 4; i++) begin
            tick(2); sda_m = 1'b0; tick(2); scl_m = 1; tick(4); scl_m = 0;
        end
        bus_stop;
        check("R10 SDA released after STOP", sda_oe, 0);
        check_cfg("R10 aborted byte not written");
        // R10 START during a data byte restarts the header
        bus_start;
        put_byte({DEV, 1'b0}, 0, ack);
        put_byte(8'h1E, 0, ack);
        for (int i = 0; i < 3; i++) begin
            tick(2); sda_m = 1'b0; tick(2); scl_m = 1; tick(4); scl_m = 0;
        end
        bus_start;
        put_byte({DEV, 1'b1}, 0, ack); check("R10 START restarts header", ack, 0);
        get_byte(1'b1, rbuf[0]);
        bus_stop;
        check("R10 read after restart", rbuf[0], exp_rd(8'h1E));
        check_cfg("R10 final config");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule